// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block looks at every pending interrupt condition in a small controller, together with each source's local enable and the processor's two mask bits. Each cycle it chooses one winner and presents that winner's vector address with a valid flag. A non-maskable pin request is gated only by its own mask bit (X) and beats everything else. All other sources are gated by the general mask bit (I) and sit in a fixed order. A 4-bit promotion register can lift any one of them to the head of that order.

The serial-port condition flags are merged into one request by a small sub-resolver before arbitration. The result is recomputed combinationally from the inputs each cycle and registered once. The output carries no data stream and has no back-pressure. It is a level that the processor samples when it is ready to take an interrupt, so there is no ready input. The vector stays valid for as long as the winning condition holds, and the consumer clears the flag that caused it.

Top module: `ivr_top`

## Requirements
- R1: The outputs are registered. A change on any input appears on `vec_valid`/`vec_addr` after the next rising clock edge. When no source qualifies, `vec_valid` is 0 and `vec_addr` is 0. During reset `vec_valid` is 0.
- R2: The non-maskable request (`xirq_req`) qualifies whenever `x_mask` is 0, whatever the value of `i_mask`. It outranks every other source and yields vector 16'hFFF4. With `x_mask` at 1 it has no effect.
- R3: While `i_mask` is 1, no source other than the non-maskable request can produce a valid vector.
- R4: Each timer-group source requests only when both its bit in `tmr_flag` and the same bit in `tmr_en` are 1.
- R5: The maskable order, highest first, is: index 0 `irq_req`; indices 1..12 `tmr_flag` bits 0..11; index 13 the SPI request; index 14 the serial-port request. The `tmr_flag` bits are, in order: real-time tick, capture 1, capture 2, capture 3, compare 1, compare 2, compare 3, compare 4, capture 4/compare 5, counter overflow, pulse-count overflow, pulse-count edge. Index k yields vector 16'hFFF2 - 2*k, so `irq_req` yields FFF2 and the serial port yields FFD6.
- R6: The promotion register resets to 4'b0101. That code promotes `irq_req`.
- R7: Promotion code c selects index c+10 for c in 0..4, index 0 for c = 5, and index c-6 for c in 6..15. A write with `prio_wr` = 1 loads `prio_wdata` at the clock edge. Arbitration uses the new code from the following cycle on. When the promoted source is requesting, it wins over all other maskable sources.
- R8: When the promoted source is not requesting, arbitration falls through to the fixed order of R5.
- R9: The serial-port request is active when any of these holds: (`sci_rx_full` or `sci_overrun`) with `sci_rx_ie`; `sci_tx_empty` with `sci_tx_ie`; `sci_tx_done` with `sci_done_ie`; `sci_idle` with `sci_idle_ie`.
- R10: The SPI request is active when `spi_ie` is 1 and either `spi_done` or `spi_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xirq_req | input | 1 | Non-maskable pin request |
| x_mask | input | 1 | Processor X mask bit |
| i_mask | input | 1 | Processor I mask bit |
| irq_req | input | 1 | Maskable external pin request |
| tmr_flag | input | 12 | Timer-group pending flags |
| tmr_en | input | 12 | Timer-group local enables |
| spi_done | input | 1 | SPI transfer-complete flag |
| spi_fault | input | 1 | SPI mode-fault flag |
| spi_ie | input | 1 | SPI interrupt enable |
| sci_rx_full | input | 1 | Serial receive buffer full |
| sci_overrun | input | 1 | Serial receive overrun |
| sci_rx_ie | input | 1 | Serial receive interrupt enable |
| sci_tx_empty | input | 1 | Serial transmit buffer empty |
| sci_tx_ie | input | 1 | Serial transmit-empty enable |
| sci_tx_done | input | 1 | Serial transmission complete |
| sci_done_ie | input | 1 | Serial complete enable |
| sci_idle | input | 1 | Serial line idle detected |
| sci_idle_ie | input | 1 | Serial idle enable |
| prio_wr | input | 1 | Load strobe for the promotion register |
| prio_wdata | input | 4 | Promotion code to load |
| vec_valid | output | 1 | A source qualifies |
| vec_addr | output | 16 | Vector address of the winner |

## Verification
The hardest case to reach is a promoted source that competes with higher fixed-order sources. The stimulus has to load a code, wait for it to take effect, and then present both the promoted source and its rivals. It also has to remove the promoted source while the rivals stay, to show the fall-through. The bench writes codes that point at both ends of the order and into the middle, at the SPI and serial requests, and at index 0. For each code it drives the promoted source together with the real-time tick or capture 1, and then drives the same rivals without it. The non-maskable path is driven with `i_mask` set and with everything else pending, so that an I-mask leak or a wrong rank would show.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int N_TMR   = 12;
  localparam int N_ISRC  = N_TMR + 3;
  localparam int IDX_W   = $clog2(N_ISRC);
  localparam int SEL_W   = 4;
  localparam int VEC_W   = 16;
  localparam int N_WRAP  = 5;
  localparam logic [SEL_W-1:0] SEL_RESET = 4'b0101;
  localparam logic [VEC_W-1:0] VEC_NMI   = 16'hFFF4;
  localparam logic [VEC_W-1:0] VEC_TOP   = 16'hFFF2;

  // promotion code -> maskable source index
  function automatic logic [IDX_W-1:0] sel_to_idx(input logic [SEL_W-1:0] c);
    int v;
    if (int'(c) < N_WRAP)       v = N_ISRC - N_WRAP + int'(c);
    else if (int'(c) == N_WRAP) v = 0;
    else                        v = int'(c) - (N_WRAP + 1);
    return IDX_W'(v);
  endfunction
endpackage

// File: rtl/ivr_sci_merge.sv
module ivr_sci_merge (
  input  logic rx_full,
  input  logic overrun,
  input  logic rx_ie,
  input  logic tx_empty,
  input  logic tx_ie,
  input  logic tx_done,
  input  logic done_ie,
  input  logic idle,
  input  logic idle_ie,
  output logic req
);
  logic rx_term, tx_term, done_term, idle_term;
  always_comb begin
    rx_term   = (rx_full | overrun) & rx_ie;
    tx_term   = tx_empty & tx_ie;
    done_term = tx_done & done_ie;
    idle_term = idle & idle_ie;
    req       = rx_term | tx_term | done_term | idle_term;
  end
endmodule

// File: rtl/ivr_pick.sv
module ivr_pick #(
  parameter int N  = 15,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] prom,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic prom_pending;
  always_comb begin
    prom_pending = (int'(prom) < N) ? req[prom] : 1'b0;
    hit = |req;
    idx = '0;
    if (prom_pending) begin
      idx = prom;
    end else begin
      for (int k = N - 1; k >= 0; k--) begin
        if (req[k]) idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/ivr_top.sv
module ivr_top
  import ivr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xirq_req,
  input  logic             x_mask,
  input  logic             i_mask,
  input  logic             irq_req,
  input  logic [N_TMR-1:0] tmr_flag,
  input  logic [N_TMR-1:0] tmr_en,
  input  logic             spi_done,
  input  logic             spi_fault,
  input  logic             spi_ie,
  input  logic             sci_rx_full,
  input  logic             sci_overrun,
  input  logic             sci_rx_ie,
  input  logic             sci_tx_empty,
  input  logic             sci_tx_ie,
  input  logic             sci_tx_done,
  input  logic             sci_done_ie,
  input  logic             sci_idle,
  input  logic             sci_idle_ie,
  input  logic             prio_wr,
  input  logic [SEL_W-1:0] prio_wdata,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr
);
  logic [SEL_W-1:0]  sel_q;
  logic [IDX_W-1:0]  prom_idx;
  logic              sci_req, spi_req, nmi_live;
  logic [N_ISRC-1:0] src_req, masked_req;
  logic              pick_hit;
  logic [IDX_W-1:0]  pick_idx;
  logic              nxt_valid;
  logic [VEC_W-1:0]  nxt_addr;

  // promotion register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= SEL_RESET;
    else if (prio_wr) sel_q <= prio_wdata;
  end
  assign prom_idx = sel_to_idx(sel_q);

  ivr_sci_merge u_sci (
    .rx_full (sci_rx_full),  .overrun (sci_overrun), .rx_ie   (sci_rx_ie),
    .tx_empty(sci_tx_empty), .tx_ie   (sci_tx_ie),   .tx_done (sci_tx_done),
    .done_ie (sci_done_ie),  .idle    (sci_idle),    .idle_ie (sci_idle_ie),
    .req     (sci_req)
  );

  assign spi_req  = spi_ie & (spi_done | spi_fault);
  assign nmi_live = xirq_req & ~x_mask;

  always_comb begin
    src_req = {sci_req, spi_req, tmr_flag & tmr_en, irq_req};
    masked_req = i_mask ? '0 : src_req;
  end

  ivr_pick #(.N(N_ISRC), .IW(IDX_W)) u_pick (
    .req (masked_req),
    .prom(prom_idx),
    .hit (pick_hit),
    .idx (pick_idx)
  );

  always_comb begin
    nxt_valid = 1'b0;
    nxt_addr  = '0;
    if (nmi_live) begin
      nxt_valid = 1'b1;
      nxt_addr  = VEC_NMI;
    end else if (pick_hit) begin
      nxt_valid = 1'b1;
      nxt_addr  = VEC_TOP - (VEC_W'(pick_idx) << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= nxt_valid;
      vec_addr  <= nxt_addr;
    end
  end

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vec_addr == '0);

  assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xirq_req && !x_mask) |=> (vec_valid && vec_addr == VEC_NMI));

  assert_imask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mask && !(xirq_req && !x_mask)) |=> !vec_valid);

  assert_vec_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[0] == 1'b0 &&
                   vec_addr >= VEC_TOP - VEC_W'(2 * (N_ISRC - 1)) &&
                   vec_addr <= VEC_NMI));

  assert_promote_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_live && !i_mask && src_req[prom_idx]) |=>
      (vec_valid && vec_addr == VEC_TOP - (VEC_W'($past(prom_idx)) << 1)));
endmodule

// File: tb/ivr_top_bench.sv
module ivr_top_bench;
  typedef struct {
    logic        v;
    logic [15:0] a;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xirq_req, x_mask, i_mask, irq_req;
  logic [11:0] tmr_flag, tmr_en;
  logic spi_done, spi_fault, spi_ie;
  logic sci_rx_full, sci_overrun, sci_rx_ie, sci_tx_empty, sci_tx_ie;
  logic sci_tx_done, sci_done_ie, sci_idle, sci_idle_ie;
  logic prio_wr;
  logic [3:0] prio_wdata;
  logic vec_valid;
  logic [15:0] vec_addr;

  int checks = 0;
  int fails = 0;
  logic [3:0] model_sel = 4'b0101;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  ivr_top u_ivr_top (
    .clk(clk), .rst_n(rst_n), .xirq_req(xirq_req), .x_mask(x_mask),
    .i_mask(i_mask), .irq_req(irq_req), .tmr_flag(tmr_flag), .tmr_en(tmr_en),
    .spi_done(spi_done), .spi_fault(spi_fault), .spi_ie(spi_ie),
    .sci_rx_full(sci_rx_full), .sci_overrun(sci_overrun), .sci_rx_ie(sci_rx_ie),
    .sci_tx_empty(sci_tx_empty), .sci_tx_ie(sci_tx_ie),
    .sci_tx_done(sci_tx_done), .sci_done_ie(sci_done_ie),
    .sci_idle(sci_idle), .sci_idle_ie(sci_idle_ie),
    .prio_wr(prio_wr), .prio_wdata(prio_wdata),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic clear_all();
    xirq_req = 0; x_mask = 0; i_mask = 0; irq_req = 0;
    tmr_flag = '0; tmr_en = '0; spi_done = 0; spi_fault = 0; spi_ie = 0;
    sci_rx_full = 0; sci_overrun = 0; sci_rx_ie = 0; sci_tx_empty = 0;
    sci_tx_ie = 0; sci_tx_done = 0; sci_done_ie = 0; sci_idle = 0;
    sci_idle_ie = 0; prio_wr = 0; prio_wdata = '0;
  endtask

  function automatic int code_index(input logic [3:0] c);
    case (c)
      4'd0: return 10;
      4'd1: return 11;
      4'd2: return 12;
      4'd3: return 13;
      4'd4: return 14;
      4'd5: return 0;
      default: return int'(c) - 6;
    endcase
  endfunction

  function automatic exp_t predict(input string tag);
    exp_t e;
    logic [14:0] r;
    int p;
    e.tag = tag; e.v = 1'b0; e.a = 16'h0000;
    if (xirq_req && !x_mask) begin
      e.v = 1'b1; e.a = 16'hFFF4;
      return e;
    end
    if (i_mask) return e;
    r[0] = irq_req;
    for (int k = 0; k < 12; k++) r[k+1] = tmr_flag[k] && tmr_en[k];
    r[13] = spi_ie && (spi_done || spi_fault);
    r[14] = (sci_rx_ie && (sci_rx_full || sci_overrun)) ||
            (sci_tx_ie && sci_tx_empty) || (sci_done_ie && sci_tx_done) ||
            (sci_idle_ie && sci_idle);
    p = code_index(model_sel);
    if (!r[p]) begin
      p = -1;
      for (int k = 14; k >= 0; k--) if (r[k]) p = k;
    end
    if (p >= 0) begin
      e.v = 1'b1;
      e.a = 16'hFFF2 - 16'(2 * p);
    end
    return e;
  endfunction

  // driver: called at a negedge with inputs already set
  task automatic step(input string tag);
    exp_q.push_back(predict(tag));
    if (prio_wr) model_sel = prio_wdata;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_sel(input logic [3:0] c);
    clear_all();
    prio_wr = 1; prio_wdata = c;
    step("R7");
    prio_wr = 0;
    step("R7");
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (vec_valid !== e.v || vec_addr !== e.a) begin
        fails++;
        $display("FAIL %s: got valid=%b addr=%h, expected valid=%b addr=%h",
                 e.tag, vec_valid, vec_addr, e.v, e.a);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear_all();
    tmr_flag = '1; tmr_en = '1; irq_req = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (vec_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset valid got %b expected 0", vec_valid);
    end
    rst_n = 1'b1;
    clear_all();
    step("R1");
    step("R1");

    // R6: reset promotion puts irq first
    irq_req = 1; tmr_flag[0] = 1; tmr_en[0] = 1; step("R6");

    // R5: each source alone
    clear_all(); irq_req = 1; step("R5");
    for (int k = 0; k < 12; k++) begin
      clear_all(); tmr_flag[k] = 1; tmr_en[k] = 1; step("R5");
    end
    clear_all(); spi_ie = 1; spi_done = 1; step("R5");
    clear_all(); sci_rx_ie = 1; sci_rx_full = 1; step("R5");
    // R5: strip winners from the top
    clear_all(); tmr_flag = '1; tmr_en = '1; spi_ie = 1; spi_done = 1;
    sci_idle = 1; sci_idle_ie = 1;
    for (int k = 0; k < 12; k++) begin
      step("R5"); tmr_flag[k] = 0;
    end
    step("R5"); spi_done = 0; step("R5"); sci_idle = 0; step("R5");

    // R4: flag without enable, enable without flag
    clear_all(); tmr_flag = '1; step("R4");
    clear_all(); tmr_en = '1; step("R4");
    clear_all(); tmr_flag = 12'h0F0; tmr_en = 12'h00F; step("R4");

    // R3 / R2
    clear_all(); i_mask = 1; irq_req = 1; tmr_flag = '1; tmr_en = '1; step("R3");
    xirq_req = 1; step("R2");
    i_mask = 0; step("R2");
    x_mask = 1; step("R2");
    irq_req = 0; tmr_flag = '0; step("R2");

    // R10
    clear_all(); spi_ie = 1; spi_fault = 1; step("R10");
    spi_ie = 0; step("R10");

    // R9: each term, and flags without enables
    clear_all(); sci_overrun = 1; sci_rx_ie = 1; step("R9");
    clear_all(); sci_tx_empty = 1; sci_tx_ie = 1; step("R9");
    clear_all(); sci_tx_done = 1; sci_done_ie = 1; step("R9");
    clear_all(); sci_idle = 1; sci_idle_ie = 1; step("R9");
    clear_all(); sci_rx_full = 1; sci_overrun = 1; sci_tx_empty = 1;
    sci_tx_done = 1; sci_idle = 1; step("R9");
    sci_rx_ie = 0; sci_tx_ie = 1; sci_tx_empty = 0; step("R9");

    // R7 / R8: promotion codes across the range
    write_sel(4'd0);
    irq_req = 1; tmr_flag[9] = 1; tmr_en[9] = 1; step("R7");
    tmr_flag[9] = 0; step("R8");
    write_sel(4'd4);
    tmr_flag[1] = 1; tmr_en[1] = 1; sci_tx_done = 1; sci_done_ie = 1; step("R7");
    sci_tx_done = 0; step("R8");
    write_sel(4'd3);
    irq_req = 1; spi_ie = 1; spi_done = 1; step("R7");
    i_mask = 1; step("R3");
    write_sel(4'd15);
    irq_req = 1; tmr_flag[8] = 1; tmr_en[8] = 1; step("R7");
    tmr_en[8] = 0; step("R8");
    write_sel(4'd7);
    irq_req = 1; tmr_flag[0] = 1; tmr_en[0] = 1; step("R7");
    tmr_flag[0] = 0; step("R8");
    write_sel(4'd6);
    irq_req = 1; tmr_flag = '1; tmr_en = '1; step("R7");
    write_sel(4'd2);
    tmr_flag[0] = 1; tmr_en[0] = 1; tmr_flag[11] = 1; tmr_en[11] = 1;
    xirq_req = 1; step("R2");
    xirq_req = 0; step("R7");

    clear_all();
    step("R1");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule